// File: doc/BRIEF.md
# JTAG Debug Transaction Port

This block sits behind a standard test access port state machine and gives an external debugger a way to reach target memory, core registers and auxiliary registers using nothing but JTAG scans. A 4-bit instruction register picks one of four data registers: a read-only status word, a command code, a 32-bit address and a 32-bit data word. The debugger loads the address, the data (for writes) and the command through DR scans. It then steps the TAP into Run-Test/Idle, which fires one request on a simple internal bus.

While the bus access is outstanding the status word shows "stalled". Once the bus acknowledges, it shows "ready" or "failure", and that result stays visible until the next launch. The debugger polls this by scanning the status register. A successful access moves the address register on by one word for memory and by one for register accesses, so a stream of words can be moved without reloading the address. Everything runs on TCK, and there is no boundary scan or IDCODE.

Top module: `dbg_scan_port`

## Requirements
- R1: Instruction codes 0x8, 0x9, 0xA and 0xB select the status (4 bits), command (4 bits), address (32 bits) and data (32 bits) registers. On every DR scan, Capture-DR loads the selected register into the shift chain, and Update-DR writes the shifted value back into it (status is read-only). The instruction register resets to 0x8.
- R2: Command codes are 0 write memory, 1 write core register, 2 write aux register, 3 no-op, 4 read memory, 5 read core register and 6 read aux register. A request drives `bus_wr` high for codes 0..2, and `bus_kind` is 0 for memory, 1 for core and 2 for aux.
- R3: A transaction starts only when the TAP moves from Update-DR or Update-IR into Run-Test/Idle. Going from Update straight to Select-DR-Scan, or leaving Test-Logic-Reset, starts nothing.
- R4: A status scan shifts out stalled first, then failure, then ready, then a constant 0. Bits shifted in during a status scan change nothing.
- R5: After a successful access the address register advances by 4 for memory commands and by 1 for core or aux commands.
- R6: Address and data shift least-significant bit first. Data register bit i appears on `bus_wdata[i]`, and `bus_rdata[i]` lands in data register bit i.
- R7: Test-Logic-Reset restores the command to 3, the address and data to 0, the status to 0 and the instruction register to 0x8.
- R8: For read commands the data register takes `bus_rdata` on the acknowledging cycle.
- R9: A memory command whose address has bit 1 or bit 0 set ends with failure set and issues no bus request.
- R10: Stalled, and `bus_req`, stay high from launch until `bus_ack`. Ready or failure then stays latched until the next launch.
- R11: The no-op command finishes at once with ready set and no bus request.
- R12: An acknowledge with `bus_err` high sets failure and leaves the address register unchanged.
- R13: Command codes 7 to 15 end with failure and no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to Test-Logic-Reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid in Shift-IR/Shift-DR |
| bus_req | output | 1 | Internal bus request, held until acknowledge |
| bus_wr | output | 1 | 1 = write access |
| bus_kind | output | 2 | 0 memory, 1 core register, 2 aux register |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access finished this cycle |
| bus_err | input | 1 | Access failed (valid with ack) |
| bus_rdata | input | 32 | Read data (valid with ack) |

## Verification
The bench goes after the launch rule. It writes a command and then makes several scans that pass from Update straight to Select-DR-Scan. A design that launched on any Update state would show a stray bus access there. Misaligned memory addresses, undefined command codes and the no-op must all finish without touching the bus; a design that skipped the checks would show an extra access or report ready. A slow acknowledge lets the bench see stalled mid-flight. Error acknowledges and successful ones are compared on the address afterwards, which catches a wrong step size or an increment on failure. Write data reaches the bus bit for bit, so a reversed shift order shows up as a scrambled word.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_t;

   // instruction codes selecting a data register
   localparam logic [3:0] SEL_STATUS = 4'h8;
   localparam logic [3:0] SEL_CMD    = 4'h9;
   localparam logic [3:0] SEL_ADDR   = 4'hA;
   localparam logic [3:0] SEL_DATA   = 4'hB;

   // command codes: bit 2 = read, bits 1:0 = access kind, 3 = no-op
   localparam logic [3:0] OP_NOP     = 4'h3;
   localparam logic [3:0] OP_FIRST_BAD = 4'h7;

   localparam logic [1:0] KIND_MEM  = 2'd0;
   localparam logic [1:0] KIND_CORE = 2'd1;
   localparam logic [1:0] KIND_AUX  = 2'd2;

endpackage

// File: rtl/dsp_tap_fsm.sv
module dsp_tap_fsm
   import dsp_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_t st
);

   tap_state_t nxt;

   always_comb begin
      unique case (st)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) st <= TS_RESET;
      else        st <= nxt;
   end

endmodule

// File: rtl/dsp_scan_chain.sv
module dsp_scan_chain #(
   parameter int CHAIN_W = 32,
   localparam int LW = $clog2(CHAIN_W + 1)
) (
   input  logic               tck,
   input  logic               rst_n,
   input  logic               capture,
   input  logic               shift,
   input  logic [LW-1:0]      len,
   input  logic [CHAIN_W-1:0] cap_val,
   input  logic               tdi,
   output logic [CHAIN_W-1:0] chain
);

   logic [CHAIN_W-1:0] shifted;

   // the active length decides where tdi enters; bits above it stay clear
   for (genvar i = 0; i < CHAIN_W; i++) begin : g_bit
      if (i == CHAIN_W - 1) begin : g_top
         assign shifted[i] = (len == LW'(CHAIN_W)) ? tdi : 1'b0;
      end else begin : g_mid
         assign shifted[i] = (LW'(i + 1) == len) ? tdi :
                             (LW'(i + 1) <  len) ? chain[i + 1] : 1'b0;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       chain <= '0;
      else if (capture) chain <= cap_val;
      else if (shift)   chain <= shifted;
   end

endmodule

// File: rtl/dsp_txn_engine.sv
module dsp_txn_engine
   import dsp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CMD_W  = 4,
   localparam int MEM_STEP = DATA_W / 8
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tap_rst,
   input  logic              launch,
   input  logic              upd_cmd,
   input  logic              upd_addr,
   input  logic              upd_data,
   input  logic [CMD_W-1:0]  cmd_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [2:0]        stat,      // {ready, failure, stalled}
   output logic              busy,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);

   logic pend;   // launch seen at Update, acted on one cycle later
   logic is_rd, is_mem, is_nop, is_bad, misalign;

   assign is_rd    = cmd_q[2];
   assign is_mem   = (cmd_q[1:0] == KIND_MEM);
   assign is_nop   = (cmd_q == CMD_W'(OP_NOP));
   assign is_bad   = (cmd_q >= CMD_W'(OP_FIRST_BAD));
   assign misalign = is_mem && (addr_q[1:0] != 2'b00);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_W'(OP_NOP);
         addr_q <= '0;
         data_q <= '0;
         stat   <= '0;
         busy   <= 1'b0;
         pend   <= 1'b0;
      end else if (tap_rst) begin
         cmd_q  <= CMD_W'(OP_NOP);
         addr_q <= '0;
         data_q <= '0;
         stat   <= '0;
         busy   <= 1'b0;
         pend   <= 1'b0;
      end else begin
         pend <= launch && !busy;
         if (upd_cmd)  cmd_q  <= cmd_in;
         if (upd_addr) addr_q <= addr_in;
         if (upd_data) data_q <= data_in;
         if (busy) begin
            if (bus_ack) begin
               busy <= 1'b0;
               if (bus_err) begin
                  stat <= 3'b010;
               end else begin
                  stat   <= 3'b100;
                  addr_q <= addr_q + (is_mem ? ADDR_W'(MEM_STEP) : ADDR_W'(1));
                  if (is_rd) data_q <= bus_rdata;
               end
            end
         end else if (pend) begin
            if (is_bad || (misalign && !is_nop)) begin
               stat <= 3'b010;
            end else if (is_nop) begin
               stat <= 3'b100;
            end else begin
               stat <= 3'b001;
               busy <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
   import dsp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              bus_req,
   output logic              bus_wr,
   output logic [1:0]        bus_kind,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);

   localparam int IR_W   = 4;
   localparam int CMD_W  = 4;
   localparam int STAT_W = 4;
   localparam int DR_W   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int DR_LW  = $clog2(DR_W + 1);
   localparam int IR_LW  = $clog2(IR_W + 1);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   tap_state_t         st;
   logic [IR_W-1:0]    ir_sh, ir_q;
   logic [DR_W-1:0]    dr_sh, dr_cap;
   logic [DR_LW-1:0]   dr_len;
   logic [CMD_W-1:0]   cmd_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic [2:0]         stat;
   logic               busy, launch;

   dsp_tap_fsm i_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .st(st));

   dsp_scan_chain #(.CHAIN_W(IR_W)) i_ir_chain (
      .tck(tck), .rst_n(rst_n),
      .capture(st == TS_CAP_IR), .shift(st == TS_SHF_IR),
      .len(IR_LW'(IR_W)), .cap_val(IR_W'(1)), .tdi(tdi), .chain(ir_sh));

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)               ir_q <= SEL_STATUS;
      else if (st == TS_RESET)  ir_q <= SEL_STATUS;
      else if (st == TS_UPD_IR) ir_q <= ir_sh;
   end

   always_comb begin
      dr_cap = '0;
      dr_len = DR_LW'(1);
      unique case (ir_q)
         SEL_STATUS: begin dr_len = DR_LW'(STAT_W); dr_cap = DR_W'({1'b0, stat}); end
         SEL_CMD:    begin dr_len = DR_LW'(CMD_W);  dr_cap = DR_W'(cmd_q);        end
         SEL_ADDR:   begin dr_len = DR_LW'(ADDR_W); dr_cap = DR_W'(addr_q);       end
         SEL_DATA:   begin dr_len = DR_LW'(DATA_W); dr_cap = DR_W'(data_q);       end
         default:    ;
      endcase
   end

   dsp_scan_chain #(.CHAIN_W(DR_W)) i_dr_chain (
      .tck(tck), .rst_n(rst_n),
      .capture(st == TS_CAP_DR), .shift(st == TS_SHF_DR),
      .len(dr_len), .cap_val(dr_cap), .tdi(tdi), .chain(dr_sh));

   assign launch = ((st == TS_UPD_DR) || (st == TS_UPD_IR)) && !tms;

   dsp_txn_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) i_eng (
      .tck(tck), .rst_n(rst_n), .tap_rst(st == TS_RESET), .launch(launch),
      .upd_cmd ((st == TS_UPD_DR) && (ir_q == SEL_CMD)),
      .upd_addr((st == TS_UPD_DR) && (ir_q == SEL_ADDR)),
      .upd_data((st == TS_UPD_DR) && (ir_q == SEL_DATA)),
      .cmd_in(dr_sh[CMD_W-1:0]), .addr_in(dr_sh[ADDR_W-1:0]),
      .data_in(dr_sh[DATA_W-1:0]),
      .cmd_q(cmd_q), .addr_q(addr_q), .data_q(data_q), .stat(stat), .busy(busy),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata));

   assign tdo = (st == TS_SHF_IR) ? ir_sh[0] :
                (st == TS_SHF_DR) ? dr_sh[0] : 1'b0;

   assign bus_req   = busy;
   assign bus_wr    = !cmd_q[2];
   assign bus_kind  = cmd_q[1:0];
   assign bus_addr  = addr_q;
   assign bus_wdata = data_q;

endmodule

// File: rtl/dsp_scan_chk.sv
module dsp_scan_chk
   import dsp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              tck,
   input logic              rst_n,
   input tap_state_t        st,
   input logic              bus_req,
   input logic              bus_ack,
   input logic              bus_err,
   input logic [1:0]        bus_kind,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [2:0]        stat,
   input logic [ADDR_W-1:0] addr_q
);

   AST_LAUNCH_FROM_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
      $rose(bus_req) |-> ($past(st) == TS_IDLE) &&
                         (($past(st, 2) == TS_UPD_DR) || ($past(st, 2) == TS_UPD_IR))); // R3

   AST_STATUS_EXCLUSIVE: assert property (@(posedge tck) disable iff (!rst_n)
      $onehot0(stat)); // R4

   AST_MEM_ALIGNED: assert property (@(posedge tck) disable iff (!rst_n)
      (bus_req && (bus_kind == KIND_MEM)) |-> (bus_addr[1:0] == 2'b00)); // R9

   AST_REQ_HELD: assert property (@(posedge tck) disable iff (!rst_n)
      (bus_req && !bus_ack && (st != TS_RESET)) |=> bus_req); // R10

   AST_ADDR_STEP: assert property (@(posedge tck) disable iff (!rst_n)
      (bus_req && bus_ack && !bus_err && (st != TS_RESET) && (st != TS_UPD_DR))
      |=> (addr_q == $past(addr_q) + (($past(bus_kind) == KIND_MEM) ? ADDR_W'(4) : ADDR_W'(1)))); // R5

endmodule

bind dbg_scan_port dsp_scan_chk #(.ADDR_W(ADDR_W)) i_chk (
   .tck(tck), .rst_n(rst_n), .st(st), .bus_req(bus_req), .bus_ack(bus_ack),
   .bus_err(bus_err), .bus_kind(bus_kind), .bus_addr(bus_addr), .stat(stat),
   .addr_q(addr_q));

// File: tb/test_dbg_scan_port.sv
module test_dbg_scan_port;

   logic        tck = 1'b0;
   logic        rst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo;
   logic        bus_req, bus_wr;
   logic [1:0]  bus_kind;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic [31:0] bus_rdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int lat = 0;
   logic resp_err = 1'b0;
   int n_access = 0;
   logic        last_wr;
   logic [1:0]  last_kind;
   logic [31:0] last_addr, last_wdata;

   dbg_scan_port i_dbg_scan_port (
      .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .bus_req(bus_req), .bus_wr(bus_wr), .bus_kind(bus_kind),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata));

   initial forever #10 tck = ~tck;

   function automatic logic [31:0] model(input logic [31:0] a);
      return a ^ 32'hA5C3_0F00;
   endfunction

   // bus responder: acknowledges after lat waiting cycles
   initial begin
      int wait_cnt = 0;
      forever begin
         @(negedge tck);
         if (bus_ack) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
         end else if (bus_req) begin
            if (wait_cnt < lat) wait_cnt++;
            else begin
               wait_cnt = 0;
               bus_ack = 1'b1;
               bus_err = resp_err;
               bus_rdata = model(bus_addr);
               last_wr = bus_wr; last_kind = bus_kind;
               last_addr = bus_addr; last_wdata = bus_wdata;
               n_access++;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge tck);
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic m);
      @(negedge tck); tms = m; tdi = 1'b0; @(posedge tck);
   endtask

   task automatic shift_bits(input int n, input logic [31:0] v, output logic [31:0] cap);
      cap = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge tck);
         cap[i] = tdo;
         tms = (i == n - 1);
         tdi = v[i];
         @(posedge tck);
      end
   endtask

   task automatic ir_scan(input logic [3:0] code);
      logic [31:0] c;
      step(1); step(1); step(0); step(0);
      shift_bits(4, 32'(code), c);
      step(1);
   endtask

   task automatic dr_scan(input int n, input logic [31:0] v, output logic [31:0] cap);
      step(1); step(0); step(0);
      shift_bits(n, v, cap);
      step(1);
   endtask

   task automatic wr_reg(input logic [3:0] sel, input int n, input logic [31:0] v);
      logic [31:0] c;
      ir_scan(sel); dr_scan(n, v, c);
   endtask

   task automatic rd_reg(input logic [3:0] sel, input int n, output logic [31:0] v);
      ir_scan(sel); dr_scan(n, 32'h0, v);
   endtask

   task automatic tap_reset();
      repeat (5) step(1);
      step(0);
   endtask

   task automatic run_cmd(input logic [31:0] a, input logic [31:0] d, input logic [3:0] c);
      wr_reg(4'hA, 32, a);
      wr_reg(4'hB, 32, d);
      wr_reg(4'h9, 4, 32'(c));
      step(0);   // Update-DR -> Run-Test/Idle launches
   endtask

   task automatic wait_done(output logic [31:0] s);
      for (int k = 0; k < 50; k++) begin
         rd_reg(4'h8, 4, s);
         if (!s[0]) break;
      end
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd_reg(4'h8, 4, v); check("R7 status after reset", v, 32'h0);
      rd_reg(4'h9, 4, v); check("R7 cmd after reset", v, 32'h3);
      rd_reg(4'hA, 32, v); check("R7 addr after reset", v, 32'h0);
      rd_reg(4'hB, 32, v); check("R1 data after reset", v, 32'h0);
   endtask

   task automatic t_mem_write();
      logic [31:0] v; int n0;
      n0 = n_access; lat = 40;
      run_cmd(32'h100, 32'hDEAD_BEEF, 4'h0);
      rd_reg(4'h8, 4, v); check("R10 stalled while pending", v, 32'h1);
      wait_done(v); check("R10 ready latched", v, 32'h4);
      rd_reg(4'h8, 4, v); check("R10 ready still held", v, 32'h4);
      check("R2 one access", 32'(n_access - n0), 32'd1);
      check("R2 write flag", 32'(last_wr), 32'd1);
      check("R2 kind mem", 32'(last_kind), 32'd0);
      check("R6 addr on bus", last_addr, 32'h100);
      check("R6 wdata lsb-first", last_wdata, 32'hDEAD_BEEF);
      rd_reg(4'hA, 32, v); check("R5 mem step 4", v, 32'h104);
      lat = 0;
   endtask

   task automatic t_core_read();
      logic [31:0] v;
      lat = 2;
      run_cmd(32'h7, 32'h0, 4'h5);
      wait_done(v); check("R8 status ready", v, 32'h4);
      check("R2 read flag", 32'(last_wr), 32'd0);
      check("R2 kind core", 32'(last_kind), 32'd1);
      rd_reg(4'hB, 32, v); check("R8 rdata captured", v, model(32'h7));
      rd_reg(4'hA, 32, v); check("R5 reg step 1", v, 32'h8);
      lat = 0;
   endtask

   task automatic t_aux_write();
      logic [31:0] v;
      run_cmd(32'h20, 32'h1234_5678, 4'h2);
      wait_done(v); check("R2 aux status", v, 32'h4);
      check("R2 kind aux", 32'(last_kind), 32'd2);
      check("R6 aux wdata", last_wdata, 32'h1234_5678);
      rd_reg(4'hA, 32, v); check("R5 aux step 1", v, 32'h21);
   endtask

   task automatic t_misaligned();
      logic [31:0] v; int n0;
      n0 = n_access;
      run_cmd(32'h102, 32'h0, 4'h4);
      wait_done(v); check("R9 failure on misaligned", v, 32'h2);
      run_cmd(32'h201, 32'h0, 4'h0);
      wait_done(v); check("R9 failure on misaligned write", v, 32'h2);
      check("R9 no bus access", 32'(n_access - n0), 32'd0);
      rd_reg(4'hA, 32, v); check("R9 addr unchanged", v, 32'h201);
   endtask

   task automatic t_nop_and_bad();
      logic [31:0] v; int n0;
      n0 = n_access;
      run_cmd(32'h103, 32'h0, 4'h3);
      wait_done(v); check("R11 nop ready", v, 32'h4);
      check("R11 nop no access", 32'(n_access - n0), 32'd0);
      run_cmd(32'h40, 32'h0, 4'h7);
      wait_done(v); check("R13 code 7 failure", v, 32'h2);
      run_cmd(32'h40, 32'h0, 4'hE);
      wait_done(v); check("R13 code 14 failure", v, 32'h2);
      check("R13 no access", 32'(n_access - n0), 32'd0);
   endtask

   task automatic t_bus_error();
      logic [31:0] v;
      resp_err = 1'b1; lat = 3;
      run_cmd(32'h200, 32'h5555_AAAA, 4'h0);
      wait_done(v); check("R12 failure on bus error", v, 32'h2);
      rd_reg(4'hA, 32, v); check("R12 addr not advanced", v, 32'h200);
      resp_err = 1'b0; lat = 0;
   endtask

   task automatic t_no_launch();
      logic [31:0] v; int n0;
      n0 = n_access;
      wr_reg(4'hA, 32, 32'h300);
      wr_reg(4'h9, 4, 32'h0);
      wr_reg(4'hB, 32, 32'h0F0F_0F0F);
      rd_reg(4'h8, 4, v); check("R3 status unchanged", v, 32'h2);
      check("R3 no launch via Select-DR", 32'(n_access - n0), 32'd0);
      step(0);
      wait_done(v); check("R3 launch via Run-Test/Idle", v, 32'h4);
      check("R3 one access", 32'(n_access - n0), 32'd1);
      tap_reset();
      check("R3 no launch from reset", 32'(n_access - n0), 32'd1);
   endtask

   task automatic t_status_ignored();
      logic [31:0] v;
      run_cmd(32'h8, 32'h0, 4'h3);
      ir_scan(4'h8); dr_scan(4, 32'hF, v);
      check("R4 status read", v, 32'h4);
      rd_reg(4'h8, 4, v); check("R4 shifted-in bits ignored", v, 32'h4);
   endtask

   task automatic t_tap_reset();
      logic [31:0] v;
      wr_reg(4'hA, 32, 32'h55);
      wr_reg(4'hB, 32, 32'h77);
      wr_reg(4'h9, 4, 32'h5);
      tap_reset();
      step(1); step(0); step(0);       // DR scan with reset instruction
      shift_bits(4, 32'h0, v); step(1);
      check("R7 IR back to status", v, 32'h0);
      rd_reg(4'h9, 4, v); check("R7 cmd default", v, 32'h3);
      rd_reg(4'hA, 32, v); check("R7 addr default", v, 32'h0);
      rd_reg(4'hB, 32, v); check("R7 data default", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge tck);
      @(negedge tck); rst_n = 1'b1;
      tap_reset();
      t_reset_state();
      t_mem_write();
      t_core_read();
      t_aux_write();
      t_misaligned();
      t_nop_and_bad();
      t_bus_error();
      t_no_launch();
      t_status_ignored();
      t_tap_reset();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule